// File: doc/BRIEF.md
# Field-Priority Interrupt Controller

This block sits between a set of level-sensitive interrupt sources and a processor core. Software programs one 4-bit priority per source, or per group of sources, in 16-bit priority words that each hold four fields. The controller ignores masked sources and sources whose priority is zero. Among the remaining pending sources it selects the one with the highest priority and presents that priority level and a fixed 12-bit event code to the core. Each source has a mask bit that software sets through one address and clears through another, so it never has to read, modify and write the mask.

The assignment of sources to fields is a parameter. Several sources can point at the same field and then share one priority. Event codes follow a fixed grid: a base value plus a constant stride for each source index. The output is held in registers. A small state machine has two states. In ST_IDLE no request is raised. In ST_REQ a request is raised. The transition T_RAISE (ST_IDLE to ST_REQ) is taken when a winner with a nonzero level exists. The transition T_DROP (ST_REQ to ST_IDLE) is taken when no winner exists. The state holds in both states otherwise.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_req is 0, irq_level is 0, irq_code is 0, every mask bit is clear and every priority field is 0.
- R2: A write with wr_addr = n (n below NUM_PREG) loads wr_data[15:0] into priority word n. Bits [4k+3:4k] of word n form field 4n+k. Source i takes its priority from the field whose number is held in SRC_FIELD[4i+3:4i]. The default mapping is: source 0 to field 0, source 1 to field 1, sources 2 and 3 to field 2, sources 4 and 5 to field 3, source 6 to field 4, source 7 to field 5.
- R3: Sources mapped to the same field share that field's priority. Writing the field changes the level of every member of the group.
- R4: A source whose priority field is 0 never raises a request, even when it is pending and unmasked.
- R5: A write to wr_addr = 4 (mask-set) sets each mask bit i for which wr_data[i] is 1. A masked source takes no part in selection. Zero bits in the written data leave the mask unchanged.
- R6: A write to wr_addr = 5 (mask-clear) clears each mask bit i for which wr_data[i] is 1. Zero bits in the written data leave the mask unchanged.
- R7: Among sources that are pending, unmasked and have a nonzero priority, the source with the highest priority value wins.
- R8: When several eligible sources share the highest priority, the source with the lowest index wins.
- R9: The event code of source i is 0x400 + 0x20*i.
- R10: The outputs are registered. They reflect the sources and registers as they stood at the previous clock edge. irq_req is 1 exactly when a winner exists, and it then carries the winner's level and code. With no winner, irq_level and irq_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: priority words, mask-set (4), mask-clear (5) |
| wr_data | input | 32 | Write data |
| src_lvl | input | 8 | Level-sensitive interrupt source inputs |
| irq_req | output | 1 | Interrupt request to the core |
| irq_level | output | 4 | Priority level of the winning source |
| irq_code | output | 12 | Event code of the winning source |

## Verification
The bench drives two members of a shared-field group together. This exposes a tie-break that favours the higher index, or a group mapping that routes one member to the wrong field; either fault shows up as code 0x460 instead of 0x440. It writes zeros to the mask-set address. A design that loads the mask instead of OR-ing into it would then unmask or mask bits unexpectedly. It checks that a zero-priority source stays silent, that the second priority word reaches the top source, and that the output does not change in the same cycle as the input. A combinational path would show the new request too early.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int FIELD_W = 4;
    localparam int CODE_W  = 12;
    localparam int WORD_W  = 16;
    localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } req_state_e;
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile
    import pic_pkg::*;
#(
    parameter int NUM_PREG      = 2,
    parameter int NUM_SRC       = 8,
    parameter int ADDR_W        = 3,
    parameter int MASK_SET_ADDR = 4,
    parameter int MASK_CLR_ADDR = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                wr_data,
    output logic [NUM_PREG*WORD_W-1:0] prio_flat,
    output logic [NUM_SRC-1:0]         mask_q
);
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(MASK_SET_ADDR);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(MASK_CLR_ADDR);

    for (genvar r = 0; r < NUM_PREG; r++) begin : g_word
        localparam logic [ADDR_W-1:0] WORD_A = ADDR_W'(r);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_flat[r*WORD_W +: WORD_W] <= '0;
            end else if (wr_en && wr_addr == WORD_A) begin
                prio_flat[r*WORD_W +: WORD_W] <= wr_data[WORD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && wr_addr == SET_A) begin
            mask_q <= mask_q | wr_data[NUM_SRC-1:0];
        end else if (wr_en && wr_addr == CLR_A) begin
            mask_q <= mask_q & ~wr_data[NUM_SRC-1:0];
        end
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int                       NUM_PREG  = 2,
    parameter int                       NUM_SRC   = 8,
    parameter logic [NUM_SRC*4-1:0]     SRC_FIELD = 32'h5433_2210,
    localparam int                      IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]          src_lvl,
    input  logic [NUM_SRC-1:0]          mask_q,
    input  logic [NUM_PREG*WORD_W-1:0]  prio_flat,
    output logic                        win_valid,
    output logic [FIELD_W-1:0]          win_lvl,
    output logic [IDX_W-1:0]            win_idx
);
    logic [FIELD_W-1:0] src_prio [NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int FLD = int'(SRC_FIELD[i*4 +: 4]);
        assign src_prio[i] = prio_flat[FLD*FIELD_W +: FIELD_W];
    end

    // Scan from the top index down so that a tie lands on the lower index.
    always_comb begin
        win_valid = 1'b0;
        win_lvl   = '0;
        win_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (src_lvl[i] && !mask_q[i] && src_prio[i] != '0 &&
                src_prio[i] >= win_lvl) begin
                win_valid = 1'b1;
                win_lvl   = src_prio[i];
                win_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import pic_pkg::*;
#(
    parameter int                   NUM_PREG      = 2,
    parameter int                   NUM_SRC       = 8,
    parameter int                   ADDR_W        = 3,
    parameter int                   MASK_SET_ADDR = 4,
    parameter int                   MASK_CLR_ADDR = 5,
    parameter int                   EVT_BASE      = 'h400,
    parameter int                   EVT_STEP      = 'h20,
    parameter logic [NUM_SRC*4-1:0] SRC_FIELD     = 32'h5433_2210
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        src_lvl,
    output logic              irq_req,
    output logic [3:0]        irq_level,
    output logic [11:0]       irq_code
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_PREG*WORD_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]         mask_w;
    logic                       win_valid;
    logic [FIELD_W-1:0]         win_lvl;
    logic [IDX_W-1:0]           win_idx;
    logic [CODE_W-1:0]          win_code;
    req_state_e                 state_q, state_d;

    pic_regfile #(
        .NUM_PREG(NUM_PREG), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
        .MASK_SET_ADDR(MASK_SET_ADDR), .MASK_CLR_ADDR(MASK_CLR_ADDR)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prio_flat(prio_flat), .mask_q(mask_w)
    );

    pic_arbiter #(
        .NUM_PREG(NUM_PREG), .NUM_SRC(NUM_SRC), .SRC_FIELD(SRC_FIELD)
    ) arb_i (
        .src_lvl(src_lvl), .mask_q(mask_w), .prio_flat(prio_flat),
        .win_valid(win_valid), .win_lvl(win_lvl), .win_idx(win_idx)
    );

    assign win_code = CODE_W'(EVT_BASE + EVT_STEP * int'(win_idx));

    // Next-state logic: T_RAISE / T_DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_valid)  state_d = ST_REQ;
            ST_REQ:  if (!win_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_level <= '0;
            irq_code  <= '0;
        end else if (state_d == ST_REQ) begin
            irq_level <= win_lvl;
            irq_code  <= win_code;
        end else begin
            irq_level <= '0;
            irq_code  <= '0;
        end
    end

    assign irq_req = (state_q == ST_REQ);
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int NUM_SRC       = 8,
    parameter int MASK_SET_ADDR = 4,
    parameter int MASK_CLR_ADDR = 5,
    parameter int EVT_BASE      = 'h400,
    parameter int EVT_STEP      = 'h20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [2:0]         wr_addr,
    input logic [31:0]        wr_data,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic [NUM_SRC-1:0] mask,
    input logic               irq_req,
    input logic [3:0]         irq_level,
    input logic [11:0]        irq_code
);
    logic [11:0] off;
    int unsigned chk_idx;
    assign off     = irq_code - 12'(EVT_BASE);
    assign chk_idx = int'(off) / EVT_STEP;

    a_r10_req_has_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_level != 4'd0);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_level == 4'd0 && irq_code == 12'd0));

    a_r9_code_grid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(off) % EVT_STEP == 0 && chk_idx < NUM_SRC));

    a_r7_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((($past(src_lvl) & ~$past(mask)) >> chk_idx) & 1) != 0);

    a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'(MASK_SET_ADDR) && wr_data[0]) |=> mask[0]);

    a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'(MASK_CLR_ADDR) && wr_data[0]) |=> !mask[0]);

    a_r5_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 3'(MASK_SET_ADDR) || wr_addr == 3'(MASK_CLR_ADDR))
         && wr_data[NUM_SRC-1:0] == '0) |=> $stable(mask));
endmodule

bind prio_intc prio_intc_chk #(
    .NUM_SRC(NUM_SRC), .MASK_SET_ADDR(MASK_SET_ADDR), .MASK_CLR_ADDR(MASK_CLR_ADDR),
    .EVT_BASE(EVT_BASE), .EVT_STEP(EVT_STEP)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_lvl(src_lvl), .mask(mask_w), .irq_req(irq_req),
    .irq_level(irq_level), .irq_code(irq_code)
);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  src_lvl = '0;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [11:0] irq_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_lvl(src_lvl), .irq_req(irq_req),
        .irq_level(irq_level), .irq_code(irq_code)
    );

    task automatic expect_out(string req, logic e_req, logic [3:0] e_lvl, logic [11:0] e_code);
        checks++;
        if (irq_req !== e_req || irq_level !== e_lvl || irq_code !== e_code) begin
            errors++;
            $display("FAIL %s: got req=%0b lvl=%h code=%h, expected req=%0b lvl=%h code=%h",
                     req, irq_req, irq_level, irq_code, e_req, e_lvl, e_code);
        end
    endtask

    // One write; the register updates at the next edge.
    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Change sources, then let one edge register the result.
    task automatic drive(logic [7:0] s);
        @(negedge clk);
        src_lvl = s;
        @(negedge clk);
    endtask

    task automatic t_reset;
        expect_out("R1 reset", 1'b0, 4'h0, 12'h000);
    endtask

    task automatic t_zero_prio;
        drive(8'hFF);
        expect_out("R4 zero priority silent", 1'b0, 4'h0, 12'h000);
        drive(8'h00);
    endtask

    task automatic t_single;
        wr(3'd0, 32'h0000_0005);
        @(negedge clk);
        src_lvl = 8'h01;
        #1;
        expect_out("R10 no same-cycle change", 1'b0, 4'h0, 12'h000);
        @(negedge clk);
        expect_out("R2/R9 source 0", 1'b1, 4'h5, 12'h400);
    endtask

    task automatic t_priority;
        wr(3'd0, 32'h0000_3A05); // f0=5 f1=0 f2=A f3=3
        drive(8'h0D);
        expect_out("R8/R3 tie in group picks src2", 1'b1, 4'hA, 12'h440);
        drive(8'h08);
        expect_out("R3 group member src3", 1'b1, 4'hA, 12'h460);
        drive(8'h11);
        expect_out("R7 higher wins src0", 1'b1, 4'h5, 12'h400);
        drive(8'h02);
        expect_out("R4 src1 field zero", 1'b0, 4'h0, 12'h000);
        wr(3'd0, 32'h0000_3705); // group f2 drops to 7
        drive(8'h0C);
        expect_out("R3 group level updated", 1'b1, 4'h7, 12'h440);
        wr(3'd0, 32'h0000_3A05);
    endtask

    task automatic t_mask;
        drive(8'h0C);
        wr(3'd4, 32'h0000_0004);
        @(negedge clk);
        expect_out("R5 masked src2", 1'b1, 4'hA, 12'h460);
        wr(3'd4, 32'h0000_0000);
        @(negedge clk);
        expect_out("R5 zero write no effect", 1'b1, 4'hA, 12'h460);
        wr(3'd4, 32'h0000_0008);
        @(negedge clk);
        expect_out("R5 both masked", 1'b0, 4'h0, 12'h000);
        wr(3'd5, 32'h0000_0000);
        @(negedge clk);
        expect_out("R6 zero write no effect", 1'b0, 4'h0, 12'h000);
        wr(3'd5, 32'h0000_0004);
        @(negedge clk);
        expect_out("R6 unmask src2", 1'b1, 4'hA, 12'h440);
        wr(3'd5, 32'h0000_00FF);
        drive(8'h00);
        expect_out("R10 idle after drop", 1'b0, 4'h0, 12'h000);
    endtask

    task automatic t_second_word;
        wr(3'd1, 32'h0000_00F0); // f4=0 f5=F
        drive(8'h84);
        expect_out("R2 word1 field5 src7", 1'b1, 4'hF, 12'h4E0);
        drive(8'h44);
        expect_out("R4 src6 field zero, src2 wins", 1'b1, 4'hA, 12'h440);
        drive(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_prio();
        t_single();
        t_priority();
        t_mask();
        t_second_word();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule